// File: doc/BRIEF.md
# Boot-Overlay Memory Map Decoder

This block turns each processor transfer address into a select for one of four RAM banks or for the boot ROM, and answers every transfer with a response. After reset it shadows the low addresses with ROM, so the processor can fetch its first instructions from address zero before RAM holds anything. The shadow is removed by the first accepted transfer that reaches the ROM at its normal base, 0x4000_0000. From then on, the ROM appears only there, and RAM is decoded from address zero.

Software describes the RAM layout through a small write port, as one start and one size per bank. It programs these so the banks tile one contiguous region. ROM responses always carry a burst-inhibit flag next to the acknowledge, so a processor that asked for a line burst repeats the line as four single long-word transfers. No response ever marks memory as uncacheable. An address that reaches neither ROM nor an enabled bank gets a bus error.

Requests enter on a valid/ready pair and responses leave on a valid/ready pair. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high whenever the one-entry response register is empty or is being drained in that cycle. A response stays on the outputs, unchanged, until `rsp_ready` takes it. The register write port has no handshake.

Top module: `boot_map_decoder`

## Requirements
- R1: After reset the overlay is active. An accepted address in 0x0000_0000..0x000F_FFFF returns rom_sel=1, ack=1, berr=0 and bank_sel=0.
- R2: While the overlay is active, no bank is selected whatever the bank registers hold. Any address outside both ROM windows returns berr=1.
- R3: The overlay clears once a request to 0x4000_0000..0x400F_FFFF is accepted, and only reset sets it again. That request itself returns a ROM response. Later low addresses decode as RAM.
- R4: With the overlay clear, a non-ROM address A selects bank i when start_i <= A < start_i + size_i. bank_sel is one-hot, and on overlapping banks the lowest index wins.
- R5: A bank whose size register is 0 is never selected.
- R6: A ROM response has ack=1, tbi=1 and burst_ok=0 whatever req_burst holds. A RAM response has ack=1, tbi=0 and burst_ok equal to the req_burst of that request.
- R7: An address that reaches neither ROM nor an enabled bank returns berr=1, ack=0, rom_sel=0 and bank_sel=0. Exactly one of ack and berr is set in every response.
- R8: rsp_cinh is 0 in every response.
- R9: A register write (cfg_field 0 = start, 1 = size, bank in cfg_idx) affects requests accepted from the next clock on. A request accepted at the same edge as the write decodes with the old value.
- R10: After reset rsp_valid=0 and req_ready=1. Each accepted request yields exactly one response, in order. req_ready = !rsp_valid or rsp_ready. A response held back by rsp_ready=0 stays stable.
- R11: The ROM window is exactly 1 MB. 0x4010_0000 after the overlay, and 0x0010_0000 during it, are not ROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sets the overlay |
| req_valid | input | 1 | Transfer start, request valid |
| req_ready | output | 1 | Request may be accepted |
| req_addr | input | 32 | Transfer address |
| req_burst | input | 1 | Processor asks for a line burst |
| cfg_we | input | 1 | Bank register write strobe |
| cfg_idx | input | 2 | Bank number to write |
| cfg_field | input | 1 | 0 = start register, 1 = size register |
| cfg_data | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_bank_sel | output | 4 | One-hot RAM bank select |
| rsp_rom_sel | output | 1 | ROM select |
| rsp_ack | output | 1 | Transfer acknowledge |
| rsp_berr | output | 1 | Bus error |
| rsp_tbi | output | 1 | Transfer burst inhibit |
| rsp_burst_ok | output | 1 | Burst granted for this RAM transfer |
| rsp_cinh | output | 1 | Cache inhibit, always 0 |

## Verification
Two kinds of event can land on the same clock edge. A bank register write can be accepted at the same edge as a request that decodes through that bank. The bench provokes this by raising cfg_we in the cycle in which req_ready lets a request into bank 0, while the write sets bank 0's size to zero. The scoreboard expects the old mapping for that request and the overlapping bank 3 for the next one. Overlay clearing meets back-pressure in the same way: the ROM-base request that clears the overlay is issued while rsp_ready toggles. The low address that follows must still decode to RAM.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  localparam int ADDR_W       = 32;
  localparam int NUM_BANKS    = 4;
  localparam int ROM_SPAN_LOG = 20;
  localparam logic [ADDR_W-1:0] ROM_BASE = 32'h4000_0000;

  typedef enum logic {
    FLD_START = 1'b0,
    FLD_SIZE  = 1'b1
  } cfg_field_e;
endpackage

// File: rtl/bmd_bank_regs.sv
module bmd_bank_regs #(
  parameter int NB = 4,
  parameter int AW = 32,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic           wr_field,
  input  logic [AW-1:0]  wr_data,
  output logic [NB*AW-1:0] start_flat,
  output logic [NB*AW-1:0] size_flat
);
  import bmd_pkg::*;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [AW-1:0] start_q, size_q;
    logic          hit_idx;
    assign hit_idx = wr_en && (wr_idx == IW'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q <= '0;
        size_q  <= '0;
      end else if (hit_idx) begin
        if (wr_field == FLD_SIZE) size_q  <= wr_data;
        else                      start_q <= wr_data;
      end
    end

    assign start_flat[b*AW +: AW] = start_q;
    assign size_flat[b*AW +: AW]  = size_q;
  end
endmodule

// File: rtl/bmd_bank_match.sv
module bmd_bank_match #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] size,
  output logic          hit
);
  logic [AW:0] a_ext, lo_ext, hi_ext;

  always_comb begin
    a_ext  = {1'b0, addr};
    lo_ext = {1'b0, start};
    hi_ext = lo_ext + {1'b0, size};
    hit    = (size != '0) && (a_ext >= lo_ext) && (a_ext < hi_ext);
  end
endmodule

// File: rtl/bmd_overlay_ctl.sv
module bmd_overlay_ctl #(
  parameter int AW = 32,
  parameter int ROM_LOG = 20,
  parameter logic [AW-1:0] ROM_BASE = 32'h4000_0000,
  localparam int TW = AW - ROM_LOG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] addr,
  output logic          overlay,
  output logic          rom_hit
);
  localparam logic [TW-1:0] BASE_TAG = ROM_BASE[AW-1:ROM_LOG];

  logic [TW-1:0] tag;
  logic          at_base, at_zero, overlay_q;

  assign tag     = addr[AW-1:ROM_LOG];
  assign at_base = (tag == BASE_TAG);
  assign at_zero = (tag == '0);
  assign rom_hit = at_base || (overlay_q && at_zero);
  assign overlay = overlay_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 overlay_q <= 1'b1;
    else if (accept && at_base) overlay_q <= 1'b0;
  end
endmodule

// File: rtl/boot_map_decoder.sv
module boot_map_decoder #(
  parameter int AW = bmd_pkg::ADDR_W,
  parameter int NUM_BANKS = bmd_pkg::NUM_BANKS,
  parameter int ROM_LOG = bmd_pkg::ROM_SPAN_LOG,
  parameter logic [AW-1:0] ROM_BASE = bmd_pkg::ROM_BASE,
  localparam int IW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [AW-1:0]        req_addr,
  input  logic                 req_burst,
  input  logic                 cfg_we,
  input  logic [IW-1:0]        cfg_idx,
  input  logic                 cfg_field,
  input  logic [AW-1:0]        cfg_data,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [NUM_BANKS-1:0] rsp_bank_sel,
  output logic                 rsp_rom_sel,
  output logic                 rsp_ack,
  output logic                 rsp_berr,
  output logic                 rsp_tbi,
  output logic                 rsp_burst_ok,
  output logic                 rsp_cinh
);
  logic [NUM_BANKS*AW-1:0] start_flat, size_flat;
  logic [NUM_BANKS-1:0]    hits, pick;
  logic                    accept, overlay_q, rom_hit;
  logic                    nxt_ack, nxt_ram;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  bmd_bank_regs #(.NB(NUM_BANKS), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_field(cfg_field), .wr_data(cfg_data),
    .start_flat(start_flat), .size_flat(size_flat)
  );

  bmd_overlay_ctl #(.AW(AW), .ROM_LOG(ROM_LOG), .ROM_BASE(ROM_BASE)) u_ovl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .addr(req_addr),
    .overlay(overlay_q), .rom_hit(rom_hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
    bmd_bank_match #(.AW(AW)) u_match (
      .addr(req_addr),
      .start(start_flat[b*AW +: AW]),
      .size(size_flat[b*AW +: AW]),
      .hit(hits[b])
    );
  end

  // Lowest-index bank wins; RAM is shut off under the overlay or on a ROM hit.
  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (!found && hits[b] && !overlay_q && !rom_hit) begin
        pick[b] = 1'b1;
        found   = 1'b1;
      end
    end
    nxt_ram = found;
    nxt_ack = found || rom_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_bank_sel <= '0;
      rsp_rom_sel  <= 1'b0;
      rsp_ack      <= 1'b0;
      rsp_berr     <= 1'b0;
      rsp_tbi      <= 1'b0;
      rsp_burst_ok <= 1'b0;
    end else if (accept) begin
      rsp_valid    <= 1'b1;
      rsp_bank_sel <= pick;
      rsp_rom_sel  <= rom_hit;
      rsp_ack      <= nxt_ack;
      rsp_berr     <= !nxt_ack;
      rsp_tbi      <= rom_hit;
      rsp_burst_ok <= nxt_ram && req_burst;
    end else if (rsp_ready) begin
      rsp_valid    <= 1'b0;
    end
  end

  assign rsp_cinh = 1'b0;
endmodule

// File: rtl/bmd_checker.sv
module bmd_checker #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [NB-1:0] rsp_bank_sel,
  input logic          rsp_rom_sel,
  input logic          rsp_ack,
  input logic          rsp_berr,
  input logic          rsp_tbi,
  input logic          rsp_burst_ok,
  input logic          overlay_q
);
  logic ovl_at_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ovl_at_acc <= 1'b1;
    else if (req_valid && req_ready) ovl_at_acc <= overlay_q;
  end

  assert_no_ram_in_overlay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && ovl_at_acc |-> rsp_bank_sel == '0);

  assert_overlay_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !overlay_q |=> !overlay_q);

  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(rsp_bank_sel) && !(rsp_rom_sel && (rsp_bank_sel != '0)));

  assert_rom_tbi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_rom_sel |-> rsp_ack && rsp_tbi && !rsp_burst_ok);

  assert_resp_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_ack != rsp_berr));

  assert_ack_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ack |-> rsp_rom_sel || (rsp_bank_sel != '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_bank_sel)
      && $stable(rsp_rom_sel) && $stable(rsp_ack) && $stable(rsp_tbi));

  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);
endmodule

bind boot_map_decoder bmd_checker #(.NB(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_bank_sel(rsp_bank_sel),
  .rsp_rom_sel(rsp_rom_sel), .rsp_ack(rsp_ack), .rsp_berr(rsp_berr),
  .rsp_tbi(rsp_tbi), .rsp_burst_ok(rsp_burst_ok), .overlay_q(overlay_q)
);

// File: tb/tb_boot_map_decoder.sv
`timescale 1ns/1ps
module tb_boot_map_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_burst = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready;
  logic        cfg_we = 1'b0, cfg_field = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [3:0]  rsp_bank_sel;
  logic        rsp_rom_sel, rsp_ack, rsp_berr, rsp_tbi, rsp_burst_ok, rsp_cinh;

  always #2 clk = ~clk;

  boot_map_decoder dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_burst(req_burst), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_field(cfg_field), .cfg_data(cfg_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_bank_sel(rsp_bank_sel),
    .rsp_rom_sel(rsp_rom_sel), .rsp_ack(rsp_ack), .rsp_berr(rsp_berr),
    .rsp_tbi(rsp_tbi), .rsp_burst_ok(rsp_burst_ok), .rsp_cinh(rsp_cinh)
  );

  typedef struct {
    logic [8:0] flds; // {sel[3:0], rom, ack, berr, tbi, burst_ok}
    string      req;
    logic [31:0] addr;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0, errors = 0;
  logic        m_ovl = 1'b1;
  logic [31:0] m_start[4], m_size[4];
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  function automatic logic [8:0] model(input logic [31:0] a, input logic bu);
    logic rom, found;
    logic [3:0] sel;
    rom = (a[31:20] == 12'h400) || (m_ovl && a[31:20] == 12'h000);
    sel = '0; found = 1'b0;
    if (!m_ovl && !rom)
      for (int i = 0; i < 4; i++)
        if (!found && m_size[i] != 0 && {1'b0, a} >= {1'b0, m_start[i]} &&
            {1'b0, a} < {1'b0, m_start[i]} + {1'b0, m_size[i]}) begin
          sel[i] = 1'b1; found = 1'b1;
        end
    return {sel, rom, rom | found, !(rom | found), rom, found & bu};
  endfunction

  task automatic issue(input logic [31:0] a, input logic bu, input string r,
                       input bit with_wr = 0, input int wi = 0,
                       input logic wf = 0, input logic [31:0] wd = 0);
    exp_t e;
    @(negedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_burst = bu;
    while (!req_ready) begin @(negedge clk); #1; end
    if (with_wr) begin
      cfg_we = 1'b1; cfg_idx = 2'(wi); cfg_field = wf; cfg_data = wd;
    end
    e.flds = model(a, bu); e.req = r; e.addr = a;
    sb.push_back(e);
    if (a[31:20] == 12'h400) m_ovl = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b0; cfg_we = 1'b0;
    if (with_wr) begin
      if (wf) m_size[wi] = wd; else m_start[wi] = wd;
    end
  endtask

  task automatic wr(input int i, input logic f, input logic [31:0] d);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_idx = 2'(i); cfg_field = f; cfg_data = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (f) m_size[i] = d; else m_start[i] = d;
  endtask

  // Monitor: owns rsp_ready, pops the scoreboard on each handshake.
  int       cyc = 0;
  bit       stalled = 0;
  logic [8:0] snap;
  always @(negedge clk) begin
    if (rst_n) begin
      logic rdy;
      exp_t e;
      cyc++;
      rdy = (cyc % 3) != 0;
      if (stalled)
        chk({rsp_valid, rsp_bank_sel, rsp_rom_sel, rsp_ack, rsp_berr, rsp_tbi,
             rsp_burst_ok} == {1'b1, snap}, "R10", "held response changed",
            {22'b0, rsp_valid, rsp_bank_sel, rsp_rom_sel, rsp_ack, rsp_berr,
             rsp_tbi, rsp_burst_ok}, {22'b0, 1'b1, snap});
      stalled = rsp_valid && !rdy;
      snap = {rsp_bank_sel, rsp_rom_sel, rsp_ack, rsp_berr, rsp_tbi, rsp_burst_ok};
      rsp_ready = rdy;
      if (rsp_valid && rdy) begin
        if (sb.size() == 0) chk(0, "R10", "response without request", 1, 0);
        else begin
          e = sb.pop_front();
          chk(snap == e.flds, e.req, $sformatf("addr %h fields", e.addr),
              {23'b0, snap}, {23'b0, e.flds});
          chk(rsp_cinh == 1'b0, "R8", "cache inhibit", {31'b0, rsp_cinh}, 0);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_start[i] = '0; m_size[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(rsp_valid == 1'b0, "R10", "reset rsp_valid", {31'b0, rsp_valid}, 0);
    chk(req_ready == 1'b1, "R10", "reset req_ready", {31'b0, req_ready}, 1);

    issue(32'h0000_0000, 1, "R1");            // overlay ROM, burst inhibited
    issue(32'h000F_FFFC, 0, "R1");
    issue(32'h0010_0000, 0, "R11");           // just past overlay window
    // Bank layout written during the overlay (R9 / R2)
    wr(0, 0, 32'h0000_0000); wr(0, 1, 32'h0080_0000);
    wr(1, 0, 32'h0080_0000); wr(1, 1, 32'h0080_0000);
    wr(2, 0, 32'h0300_0000);                   // size stays 0
    wr(3, 0, 32'h0100_0000); wr(3, 1, 32'h0100_0000);
    issue(32'h0080_0000, 0, "R2");            // RAM disabled under overlay
    issue(32'h4000_0010, 1, "R3");            // clears overlay, ROM answers
    issue(32'h0000_0000, 1, "R3");            // now bank 0, burst granted
    issue(32'h007F_FFFC, 0, "R4");
    issue(32'h0080_0000, 1, "R4");
    issue(32'h01FF_FFFC, 0, "R4");
    issue(32'h0200_0000, 0, "R7");            // past end of RAM
    issue(32'h4010_0000, 0, "R11");           // past 1 MB ROM window
    issue(32'h400F_FFFC, 1, "R6");
    issue(32'h0300_0000, 0, "R5");            // bank 2 has size 0
    wr(3, 0, 32'h0000_0000);                   // bank 3 overlaps 0 and 1
    issue(32'h0090_0000, 0, "R4");            // bank 1 beats bank 3
    issue(32'h0000_1000, 0, "R4");            // bank 0 beats bank 3
    issue(32'h0000_0040, 1, "R9", 1, 0, 1, 32'h0); // same-edge write: old map
    issue(32'h0000_0040, 1, "R9");            // bank 0 now empty -> bank 3
    issue(32'h0000_0080, 0, "R6");
    for (int k = 0; k < 6; k++)
      issue(32'h0080_0000 + 32'(k) * 32'h0010_0000, k[0], "R4");

    for (int k = 0; k < 50 && sb.size() != 0; k++) @(negedge clk);
    chk(sb.size() == 0, "R10", "responses outstanding", sb.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule